// File: doc/BRIEF.md
# Recursive Switching Median Corrector

This block repairs impulse-corrupted pixels of an image held in an external RAM. Once started, it walks a per-pixel noise map in raster order, one cell at a time. When a cell holds one of the two noise codes, the block collects the pixels around that position, takes their median with the flagged pixel itself left out, and writes the result back into the image RAM at the flagged position. Cells with any other code produce no image access at all.

The write happens in place. A later window that overlaps an earlier repaired pixel therefore sees the repaired value, not the corrupted one, so the filter is recursive. A mode input, sampled at start, selects a 3×3 or a 5×5 neighbourhood. Neighbours that would fall outside the image are dropped, so the median population shrinks near the borders. Whenever that population has an even size, the result is the mean of its two middle values, rounded down.

Both RAMs are read synchronously with one cycle of latency. The noise map and the image share the same raster addressing: the address of pixel (x, y) is y·width + x.

Top module: `impulse_fixer`

## Requirements
- R1: While reset is low and after it, until a start arrives, `busy`, `done`, `map_rd`, `img_rd` and `img_we` are all low.
- R2: A start in idle makes the block read every map cell exactly once, at addresses 0, 1, 2, … up to the last pixel, in increasing order.
- R3: Only the map codes 5'b01001 and 5'b10111 start a correction. Any other code leaves the pixel untouched and causes no image write.
- R4: The flagged pixel is never read and is never part of the median. In 3×3 mode an interior pixel uses exactly its 8 neighbours.
- R5: With an even number of neighbours, the result is floor((a+b)/2), where a and b are the two middle values of the sorted neighbours.
- R6: Neighbours outside the image are skipped. At a corner in 3×3 mode 3 values remain; on an edge 5 remain. The result is the middle value of those.
- R7: In 5×5 mode (`wide_mode` = 1 at start), an interior pixel uses its 24 neighbours, and a corner pixel uses the 8 that lie inside the image.
- R8: Each result overwrites the flagged pixel before the next map cell is examined, so later windows use values that are already corrected.
- R9: `done` is high for exactly one cycle after the last map cell is handled, and `busy` is low after it. A start asserted while `busy` is high has no effect.
- R10: Every image write goes to the address of the map cell being handled, and reads and writes never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a scan when idle |
| wide_mode | input | 1 | 1 selects a 5×5 window, 0 selects 3×3 (sampled at start) |
| map_rd | output | 1 | Noise map read strobe |
| map_addr | output | AW | Noise map address (raster order) |
| map_rdata | input | CODE_W | Map cell contents, valid one cycle after `map_rd` |
| img_rd | output | 1 | Image read strobe |
| img_we | output | 1 | Image write strobe |
| img_addr | output | AW | Image address for a read or a write |
| img_wdata | output | PIX_W | Corrected pixel value |
| img_rdata | input | PIX_W | Image read data, valid one cycle after `img_rd` |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |

## Verification
A wrong neighbour offset or a broken border test shows up as a wrong value in the image RAM, at the flagged pixel, as soon as that window is written. A broken border test can also show up as a read of the flagged address in the same cycle it happens. A median rank or rounding error appears directly in the written value. The directed windows use values in ascending order with a distinct background, so an included outsider or a dropped neighbour moves the result by a visible amount. A loss of the in-place ordering appears only at the second of two adjacent flagged pixels, so a dedicated pair pattern separates the recursive result from the non-recursive one. A wrong scan counter shows as an out-of-order map address or a wrong read count when `done` pulses.

// File: rtl/impulse_fixer_pkg.sv
// Shared definitions for the recursive median corrector.
// Assumes a window of at most 5x5, kept as 25 slots in raster order.
package impulse_fixer_pkg;
    localparam int SLOTS = 25;
    localparam int SLOT_IW = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAP_RD,
        ST_MAP_CHK,
        ST_GATHER,
        ST_FLUSH,
        ST_MED,
        ST_WAIT,
        ST_DONE
    } fix_state_t;
endpackage

// File: rtl/impulse_fixer_nbr.sv
// Neighbour address generator: adds a signed offset (-2..2) to the centre
// coordinates. It flags the result usable only if it lies inside the image
// and is not the centre itself. Assumes offsets never exceed +/-2.
module impulse_fixer_nbr #(
    parameter int IMG_W = 16,
    parameter int IMG_H = 16,
    parameter int AW = 8,
    parameter int XW = 4,
    parameter int YW = 4
) (
    input  logic [XW-1:0]     cx,
    input  logic [YW-1:0]     cy,
    input  logic signed [2:0] dx,
    input  logic signed [2:0] dy,
    output logic              ok,
    output logic [AW-1:0]     addr
);
    logic signed [XW+1:0] nx;
    logic signed [YW+1:0] ny;

    // Compute the neighbour position, its validity and its raster address.
    always_comb begin
        nx = $signed({2'b00, cx}) + {{(XW-1){dx[2]}}, dx};
        ny = $signed({2'b00, cy}) + {{(YW-1){dy[2]}}, dy};
        ok = !nx[XW+1] && !ny[YW+1]
             && (nx < $signed((XW+2)'(IMG_W)))
             && (ny < $signed((YW+2)'(IMG_H)))
             && !((dx == 3'sd0) && (dy == 3'sd0));
        addr = AW'(32'(ny[YW-1:0]) * IMG_W + 32'(nx[XW-1:0]));
    end
endmodule

// File: rtl/impulse_fixer_gather.sv
// Serial-to-parallel collector: stores each returned pixel into its window
// slot and marks that slot valid. Assumes clear and capture never coincide.
module impulse_fixer_gather
    import impulse_fixer_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         cap_en,
    input  logic [SLOT_IW-1:0]           cap_idx,
    input  logic [PIX_W-1:0]             data,
    output logic [SLOTS-1:0][PIX_W-1:0]  vals,
    output logic [SLOTS-1:0]             mask
);
    // Capture one pixel per cycle, or empty the window for a new centre.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vals <= '0;
            mask <= '0;
        end else if (clear) begin
            mask <= '0;
        end else if (cap_en) begin
            vals[cap_idx] <= data;
            mask[cap_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/impulse_fixer_median.sv
// Two-stage median of the masked slots. The first stage ranks every valid
// value, with ties broken by slot index. The second stage picks the two
// middle ranks and averages them, rounding down. The result is valid two
// clocks after in_valid, whatever the count. Assumes at least one slot is valid.
module impulse_fixer_median
    import impulse_fixer_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [SLOTS-1:0][PIX_W-1:0]  vals,
    input  logic [SLOTS-1:0]             mask,
    output logic                         out_valid,
    output logic [PIX_W-1:0]             out_val
);
    localparam int RW = $clog2(SLOTS + 1);

    logic [SLOTS-1:0][RW-1:0]    rank_c, rank_q;
    logic [SLOTS-1:0][PIX_W-1:0] vals_q;
    logic [SLOTS-1:0]            mask_q;
    logic [RW-1:0]               cnt_c, cnt_q, lo_rank, hi_rank;
    logic                        v1_q;
    logic [PIX_W-1:0]            lo_val, hi_val;
    logic [PIX_W:0]              sum;

    // Stage 1 logic: sorted position of every valid slot.
    always_comb begin
        cnt_c = RW'($countones(mask));
        for (int i = 0; i < SLOTS; i++) begin
            rank_c[i] = '0;
            for (int j = 0; j < SLOTS; j++) begin
                if (mask[j] && (j != i) &&
                    ((vals[j] < vals[i]) || ((vals[j] == vals[i]) && (j < i))))
                    rank_c[i] = rank_c[i] + RW'(1);
            end
        end
    end

    // Stage 1 register: ranks, values and population size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_q <= '0;
            vals_q <= '0;
            mask_q <= '0;
            cnt_q  <= '0;
            v1_q   <= 1'b0;
        end else begin
            rank_q <= rank_c;
            vals_q <= vals;
            mask_q <= mask;
            cnt_q  <= cnt_c;
            v1_q   <= in_valid;
        end
    end

    // Stage 2 logic: select the two middle values and form their mean.
    always_comb begin
        lo_rank = (cnt_q - RW'(1)) >> 1;
        hi_rank = cnt_q >> 1;
        lo_val  = '0;
        hi_val  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (mask_q[i] && (rank_q[i] == lo_rank)) lo_val = vals_q[i];
            if (mask_q[i] && (rank_q[i] == hi_rank)) hi_val = vals_q[i];
        end
        sum = {1'b0, lo_val} + {1'b0, hi_val};
    end

    // Stage 2 register: the result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_val   <= '0;
        end else begin
            out_valid <= v1_q;
            out_val   <= sum[PIX_W:1];
        end
    end
endmodule

// File: rtl/impulse_fixer.sv
// Recursive switching median corrector. It scans the noise map in raster
// order. For each flagged cell it reads the in-image neighbours one by one,
// takes their median without the centre, and writes it back in place.
// Assumes both RAMs have a one-cycle read latency and that the image is at
// least 3x3.
module impulse_fixer
    import impulse_fixer_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 16,
    parameter int PIX_W = 8,
    parameter int CODE_W = 5,
    parameter logic [CODE_W-1:0] SALT_CODE = 5'b01001,
    parameter logic [CODE_W-1:0] PEPPER_CODE = 5'b10111,
    localparam int NPIX = IMG_W * IMG_H,
    localparam int AW = $clog2(NPIX),
    localparam int XW = $clog2(IMG_W),
    localparam int YW = $clog2(IMG_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide_mode,
    output logic              map_rd,
    output logic [AW-1:0]     map_addr,
    input  logic [CODE_W-1:0] map_rdata,
    output logic              img_rd,
    output logic              img_we,
    output logic [AW-1:0]     img_addr,
    output logic [PIX_W-1:0]  img_wdata,
    input  logic [PIX_W-1:0]  img_rdata,
    output logic              busy,
    output logic              done
);
    fix_state_t               state;
    logic [AW-1:0]            pix;
    logic [XW-1:0]            cx;
    logic [YW-1:0]            cy;
    logic signed [2:0]        dx, dy, rad;
    logic                     mode_q, flagged, last_pix, win_end, advance;
    logic                     nb_ok, cap_en, med_valid;
    logic [AW-1:0]            nb_addr;
    logic [SLOT_IW-1:0]       cap_idx, slot_idx;
    logic [2:0]               dxo, dyo;
    logic [SLOTS-1:0][PIX_W-1:0] slot_val;
    logic [SLOTS-1:0]         slot_ok;
    logic [PIX_W-1:0]         med_val;

    // Decode the window radius, the noise codes and the scan end conditions.
    always_comb begin
        rad      = mode_q ? 3'sd2 : 3'sd1;
        flagged  = (map_rdata == SALT_CODE) || (map_rdata == PEPPER_CODE);
        last_pix = (pix == AW'(NPIX - 1));
        win_end  = (dx == rad) && (dy == rad);
        advance  = ((state == ST_MAP_CHK) && !flagged) ||
                   ((state == ST_WAIT) && med_valid);
        dxo      = dx + 3'sd2;
        dyo      = dy + 3'sd2;
        slot_idx = SLOT_IW'(dyo) * SLOT_IW'(5) + SLOT_IW'(dxo);
    end

    impulse_fixer_nbr #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .AW(AW), .XW(XW), .YW(YW)
    ) u_nbr (
        .cx(cx), .cy(cy), .dx(dx), .dy(dy), .ok(nb_ok), .addr(nb_addr)
    );

    impulse_fixer_gather #(.PIX_W(PIX_W)) u_gather (
        .clk(clk), .rst_n(rst_n),
        .clear(state == ST_MAP_CHK),
        .cap_en(cap_en), .cap_idx(cap_idx), .data(img_rdata),
        .vals(slot_val), .mask(slot_ok)
    );

    impulse_fixer_median #(.PIX_W(PIX_W)) u_median (
        .clk(clk), .rst_n(rst_n),
        .in_valid(state == ST_MED),
        .vals(slot_val), .mask(slot_ok),
        .out_valid(med_valid), .out_val(med_val)
    );

    // Sequence the scan: map lookup, neighbour reads, median, write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pix     <= '0;
            cx      <= '0;
            cy      <= '0;
            dx      <= '0;
            dy      <= '0;
            mode_q  <= 1'b0;
            cap_en  <= 1'b0;
            cap_idx <= '0;
        end else begin
            cap_en  <= (state == ST_GATHER) && nb_ok;
            cap_idx <= slot_idx;
            case (state)
                ST_IDLE: if (start) begin
                    mode_q <= wide_mode;
                    pix    <= '0;
                    cx     <= '0;
                    cy     <= '0;
                    state  <= ST_MAP_RD;
                end
                ST_MAP_RD:  state <= ST_MAP_CHK;
                ST_MAP_CHK: if (flagged) begin
                    dx    <= 3'sd0 - rad;
                    dy    <= 3'sd0 - rad;
                    state <= ST_GATHER;
                end
                ST_GATHER: begin
                    if (win_end) begin
                        state <= ST_FLUSH;
                    end else if (dx == rad) begin
                        dx <= 3'sd0 - rad;
                        dy <= dy + 3'sd1;
                    end else begin
                        dx <= dx + 3'sd1;
                    end
                end
                ST_FLUSH: state <= ST_MED;
                ST_MED:   state <= ST_WAIT;
                ST_DONE:  state <= ST_IDLE;
                default: ;
            endcase
            if (advance) begin
                if (last_pix) begin
                    state <= ST_DONE;
                end else begin
                    pix   <= pix + AW'(1);
                    state <= ST_MAP_RD;
                    if (cx == XW'(IMG_W - 1)) begin
                        cx <= '0;
                        cy <= cy + YW'(1);
                    end else begin
                        cx <= cx + XW'(1);
                    end
                end
            end
        end
    end

    // Drive the memory strobes and the status outputs from the state.
    always_comb begin
        map_rd    = (state == ST_MAP_RD);
        map_addr  = pix;
        img_rd    = (state == ST_GATHER) && nb_ok;
        img_we    = (state == ST_WAIT) && med_valid;
        img_addr  = (state == ST_WAIT) ? pix : nb_addr;
        img_wdata = med_val;
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
    end
endmodule

// File: rtl/impulse_fixer_chk.sv
// Protocol checker for the corrector's memory ports and its status outputs.
// Assumes the map address stays on the current centre while that centre
// is being processed.
module impulse_fixer_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          map_rd,
    input logic [AW-1:0] map_addr,
    input logic          img_rd,
    input logic          img_we,
    input logic [AW-1:0] img_addr,
    input logic          busy,
    input logic          done
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(map_rd || img_rd || img_we || done));

    assert_scan_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (map_rd && (map_addr == '0)));

    assert_single_map_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        map_rd |=> !map_rd);

    assert_centre_not_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        img_rd |-> (img_addr != map_addr));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_busy_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_start_in_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    assert_write_at_centre_R10: assert property (@(posedge clk) disable iff (!rst_n)
        img_we |-> (img_addr == map_addr));

    assert_rw_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(img_we && img_rd));
endmodule

bind impulse_fixer impulse_fixer_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .map_rd(map_rd),
    .map_addr(map_addr), .img_rd(img_rd), .img_we(img_we),
    .img_addr(img_addr), .busy(busy), .done(done)
);

// File: tb/test_impulse_fixer.sv
`timescale 1ns/1ps
// Directed bench for the recursive median corrector, on an 8x6 image.
module test_impulse_fixer;
    localparam int W = 8;
    localparam int H = 6;
    localparam int NPIX = W * H;
    localparam int AW = $clog2(NPIX);
    localparam logic [4:0] SALT = 5'b01001;
    localparam logic [4:0] PEPPER = 5'b10111;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wide = 1'b0, load = 1'b0;
    logic map_rd, img_rd, img_we, busy, done;
    logic [AW-1:0] map_addr, img_addr;
    logic [4:0] map_rdata;
    logic [7:0] img_rdata, img_wdata;

    logic [7:0] img_mem [NPIX];
    logic [4:0] map_mem [NPIX];
    logic [7:0] init_img [NPIX];
    logic [4:0] init_map [NPIX];
    int ref_img [NPIX];
    int map_cnt, wr_cnt, ord_err, ctr_err, done_cnt;
    int n_tests = 0, n_fail = 0;
    int seed = 7;

    always #5 clk = ~clk;

    impulse_fixer #(.IMG_W(W), .IMG_H(H)) i_impulse_fixer (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide),
        .map_rd(map_rd), .map_addr(map_addr), .map_rdata(map_rdata),
        .img_rd(img_rd), .img_we(img_we), .img_addr(img_addr),
        .img_wdata(img_wdata), .img_rdata(img_rdata),
        .busy(busy), .done(done)
    );

    // RAM models with one-cycle read latency, plus port monitors.
    always @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < NPIX; i++) begin
                img_mem[i] <= init_img[i];
                map_mem[i] <= init_map[i];
            end
            map_cnt <= 0; wr_cnt <= 0; ord_err <= 0; ctr_err <= 0; done_cnt <= 0;
        end else begin
            if (map_rd) begin
                map_rdata <= map_mem[map_addr];
                if (int'(map_addr) != map_cnt) ord_err <= ord_err + 1;
                map_cnt <= map_cnt + 1;
            end
            if (img_rd) begin
                img_rdata <= img_mem[img_addr];
                if (img_addr == map_addr) ctr_err <= ctr_err + 1;
            end
            if (img_we) begin
                img_mem[img_addr] <= img_wdata;
                wr_cnt <= wr_cnt + 1;
                if (img_addr != map_addr || img_rd) ctr_err <= ctr_err + 1;
            end
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff;
    endfunction

    task automatic load_mem();
        @(negedge clk) load = 1'b1;
        @(negedge clk) load = 1'b0;
    endtask

    // Start a scan, optionally pulse start again mid-run, wait for idle.
    task automatic run(input bit w, input int extra_at);
        int c;
        wide = w;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        c = 0;
        while (busy && c < 20000) begin
            @(negedge clk);
            c++;
            start = (c == extra_at);
        end
        start = 1'b0;
        chk(c < 20000, "R9 watchdog", c, 20000);
    endtask

    // Recursive reference model built from the requirements.
    task automatic ref_fix(input bit w);
        int r, n, t, b[25];
        r = w ? 2 : 1;
        for (int p = 0; p < NPIX; p++) ref_img[p] = init_img[p];
        for (int p = 0; p < NPIX; p++) begin
            if (init_map[p] == SALT || init_map[p] == PEPPER) begin
                n = 0;
                for (int dy = -r; dy <= r; dy++)
                    for (int dx = -r; dx <= r; dx++) begin
                        int x = p % W + dx;
                        int y = p / W + dy;
                        if (!(dx == 0 && dy == 0) && x >= 0 && x < W && y >= 0 && y < H) begin
                            b[n] = ref_img[y * W + x];
                            n++;
                        end
                    end
                for (int i = 1; i < n; i++)
                    for (int j = i; j > 0 && b[j-1] > b[j]; j--) begin
                        t = b[j]; b[j] = b[j-1]; b[j-1] = t;
                    end
                ref_img[p] = (b[(n-1)/2] + b[n/2]) / 2;
            end
        end
    endtask

    task automatic t_reset();
        chk(!busy && !done && !map_rd && !img_rd && !img_we, "R1 outputs in reset",
            {busy, done, map_rd, img_rd, img_we}, 0);
    endtask

    // Non-trigger codes everywhere: full ordered scan, no writes.
    task automatic t_no_flags();
        int diffs = 0;
        logic [4:0] codes [5] = '{5'b01000, 5'b11111, 5'b00000, 5'b01011, 5'b10110};
        for (int p = 0; p < NPIX; p++) begin
            init_img[p] = 8'(rnd());
            init_map[p] = codes[p % 5];
        end
        load_mem();
        run(1'b0, -1);
        for (int p = 0; p < NPIX; p++) if (img_mem[p] != init_img[p]) diffs++;
        chk(diffs == 0, "R3 image unchanged", diffs, 0);
        chk(wr_cnt == 0, "R3 no writes", wr_cnt, 0);
        chk(map_cnt == NPIX, "R2 map read count", map_cnt, NPIX);
        chk(ord_err == 0, "R2 raster order", ord_err, 0);
        chk(done_cnt == 1 && !busy, "R9 single done", done_cnt, 1);
    endtask

    // One flagged centre; neighbours base+step*k in raster order, rest 200.
    task automatic t_window(input int cx, input int cy, input bit w, input int base,
                            input int step, input int expv, input string req);
        int k = 0, r, c, diffs = 0;
        r = w ? 2 : 1;
        c = cy * W + cx;
        for (int p = 0; p < NPIX; p++) begin init_img[p] = 8'd200; init_map[p] = 5'b0; end
        for (int dy = -r; dy <= r; dy++)
            for (int dx = -r; dx <= r; dx++)
                if (!(dx == 0 && dy == 0) && cx+dx >= 0 && cx+dx < W && cy+dy >= 0 && cy+dy < H) begin
                    init_img[(cy+dy)*W + cx+dx] = 8'(base + step * k);
                    k++;
                end
        init_img[c] = 8'd250;
        init_map[c] = (cx % 2 == 0) ? SALT : PEPPER;
        load_mem();
        run(w, -1);
        chk(img_mem[c] == 8'(expv), req, img_mem[c], expv);
        for (int p = 0; p < NPIX; p++) if (p != c && img_mem[p] != init_img[p]) diffs++;
        chk(diffs == 0 && wr_cnt == 1, "R3 only centre written", diffs + wr_cnt, 1);
        chk(ctr_err == 0, "R4 R10 centre access", ctr_err, 0);
    endtask

    // Two adjacent flags whose second result depends on the first repair.
    task automatic t_recursive_pair();
        for (int p = 0; p < NPIX; p++) begin init_img[p] = 8'd200; init_map[p] = 5'b0; end
        init_img[1*W+1] = 20; init_img[2*W+1] = 30; init_img[3*W+1] = 40;
        init_img[1*W+2] = 10; init_img[1*W+3] = 10; init_img[1*W+4] = 10;
        init_img[3*W+2] = 90; init_img[3*W+3] = 90; init_img[3*W+4] = 90;
        init_img[2*W+4] = 90;
        init_img[2*W+2] = 255; init_map[2*W+2] = SALT;
        init_img[2*W+3] = 0;   init_map[2*W+3] = PEPPER;
        load_mem();
        run(1'b0, -1);
        chk(img_mem[2*W+2] == 8'd25, "R8 first repair", img_mem[2*W+2], 25);
        chk(img_mem[2*W+3] == 8'd57, "R8 uses repaired value", img_mem[2*W+3], 57);
    endtask

    // Random image with random flags, compared with the reference model.
    task automatic t_random(input bit w, input int extra_at);
        int diffs = 0;
        for (int p = 0; p < NPIX; p++) begin
            init_img[p] = 8'(rnd());
            case (rnd() % 5)
                0: init_map[p] = SALT;
                1: init_map[p] = PEPPER;
                default: init_map[p] = 5'(rnd());
            endcase
        end
        ref_fix(w);
        load_mem();
        run(w, extra_at);
        for (int p = 0; p < NPIX; p++) if (int'(img_mem[p]) != ref_img[p]) diffs++;
        chk(diffs == 0, w ? "R7 R8 random 5x5" : "R8 random 3x3", diffs, 0);
        chk(map_cnt == NPIX, "R9 start ignored while busy", map_cnt, NPIX);
        chk(done_cnt == 1 && !busy && !done, "R9 done pulse", done_cnt, 1);
        chk(ctr_err == 0, "R10 write address", ctr_err, 0);
    endtask

    initial begin
        #1500000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_flags();
        t_window(3, 2, 1'b0, 1, 1, 4, "R5 interior 3x3 floor mean");
        t_window(3, 2, 1'b0, 10, 10, 45, "R4 R5 interior 3x3");
        t_window(0, 0, 1'b0, 10, 10, 20, "R6 corner 3x3");
        t_window(0, 3, 1'b0, 10, 10, 30, "R6 edge 3x3");
        t_window(3, 3, 1'b1, 1, 1, 12, "R7 interior 5x5");
        t_window(3, 3, 1'b1, 0, 3, 34, "R7 interior 5x5 spread");
        t_window(7, 5, 1'b1, 10, 10, 45, "R7 corner 5x5");
        t_recursive_pair();
        t_random(1'b0, 10);
        t_random(1'b1, 40);
        t_random(1'b0, -1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule